// File: doc/BRIEF.md
# Virtual-to-Physical Partition ID Translator

This block turns the small virtual partition ID carried by a request into the physical partition ID that the resource-control hardware further down uses. Software fills a table of 64-bit mapping registers through a register write/read port. Each register holds four 16-bit physical IDs. Software also writes a separate bitmap that marks which table entries are usable.

The translate side is purely combinational. It takes a virtual ID, a flag that says whether the request comes from the user level or the kernel level, one mapping-enable bit per level, and a flag that says whether the hypervisor level is enabled. When mapping applies, the block looks up the table. It returns the physical ID or raises a fault. When mapping does not apply, the virtual ID passes straight through.

The number of implemented registers is set at build time by `MAX_REG_IDX`, the highest register index, from 0 to 7. The table therefore covers from 4 up to 32 virtual IDs.

Top module: `vpart_map`

## Requirements
- R1: Virtual ID v maps to register v/4, entry v%4. Entry k of a register occupies bits [16k+15:16k], so entry 0 is in bits [15:0] and entry 3 is in bits [63:48].
- R2: Register addresses 0..`MAX_REG_IDX` select the mapping registers, and address 8 selects the valid bitmap. Bit n of the bitmap belongs to virtual ID n. Bitmap bits at or above the number of entries are neither stored nor read back; they read as 0.
- R3: While mapping applies, a virtual ID whose valid bit is 0 drives `xlFault` to 1 and `pidOut` to 0.
- R4: While mapping applies, a virtual ID at or above 4*(`MAX_REG_IDX`+1) drives `xlFault` to 1 and `pidOut` to 0.
- R5: A kernel-level request (`reqUser`=0) is mapped only when `kernMapEn` is 1. A user-level request (`reqUser`=1) is mapped only when `userMapEn` is 1. An unmapped request returns the virtual ID zero-extended on `pidOut`, with `xlFault` at 0.
- R6: With `hypEnabled` at 0, every request passes through unchanged with no fault, whatever the enables and the table hold.
- R7: Unless `featPresent` and `hypCtlPresent` are both 1:
  - any register access raises `regUndef`;
  - writes are dropped;
  - reads return 0;
  - translation passes through.
- R8: An access to an address that is neither an implemented mapping register nor address 8 raises `regUndef`. A write there changes nothing, and a read there returns 0.
- R9: After reset, all mapping registers and the valid bitmap are 0.
- R10: A write takes effect at the clock edge on which `regWrEn` is sampled high. Both readback and translation show the new value from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| featPresent | input | 1 | Partitioning feature implemented |
| hypCtlPresent | input | 1 | Hypervisor partition control implemented |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 4 | Register address (0..7 mapping, 8 valid bitmap) |
| regWrData | input | 64 | Write data |
| regRdData | output | 64 | Read data (combinational) |
| regUndef | output | 1 | Access is undefined |
| hypEnabled | input | 1 | Hypervisor level enabled in current security state |
| kernMapEn | input | 1 | Mapping enable for kernel-level IDs |
| userMapEn | input | 1 | Mapping enable for user-level IDs |
| reqUser | input | 1 | Request level: 1 user, 0 kernel |
| vidIn | input | VID_W | Virtual partition ID |
| pidOut | output | 16 | Physical partition ID |
| xlFault | output | 1 | Translation fault |

## Verification
Some behaviours are checked by assertions on every cycle:
- a fault always carries a zero ID;
- out-of-range IDs fault whenever mapping applies;
- an unmapped request never faults;
- an undefined access never produces a write strobe;
- the valid bitmap changes only on a decoded write, and then takes the written value.

Other behaviours only the directed scenarios can show. These are the entry packing within a register, the choice of enable by request level, the write-then-translate timing, and the readback of zero from unimplemented or absent registers. Those scenarios drive each one and compare against values worked out from the requirements.

// File: rtl/vpm_pkg.sv
package vpm_pkg;
  localparam int ADDR_W      = 4;
  localparam int VALID_ADDR  = 8;
  localparam int MAP_W       = 64;
  localparam int ENT_PER_REG = 4;
  localparam int ENT_W       = MAP_W / ENT_PER_REG;

  typedef struct packed {
    logic       wrMap;
    logic       wrValid;
    logic       rdMap;
    logic       rdValid;
    logic [2:0] regSel;
    logic       mapActive;
  } vpmStrb_t;
endpackage

// File: rtl/vpm_ctrl.sv
module vpm_ctrl
  import vpm_pkg::*;
#(
  parameter int MAX_REG_IDX = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              featPresent,
  input  logic              hypCtlPresent,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              hypEnabled,
  input  logic              kernMapEn,
  input  logic              userMapEn,
  input  logic              reqUser,
  output vpmStrb_t          strb,
  output logic              regUndef
);
  localparam logic [ADDR_W-1:0] LAST_MAP = ADDR_W'(MAX_REG_IDX);
  localparam logic [ADDR_W-1:0] VLD_ADDR = ADDR_W'(VALID_ADDR);

  logic tablePresent, addrIsMap, addrIsValid, addrOk, levelEn;

  always_comb begin
    tablePresent = featPresent && hypCtlPresent;
    addrIsMap    = regAddr <= LAST_MAP;
    addrIsValid  = regAddr == VLD_ADDR;
    addrOk       = tablePresent && (addrIsMap || addrIsValid);
    regUndef     = (regWrEn || regRdEn) && !addrOk;
    levelEn      = reqUser ? userMapEn : kernMapEn;

    strb.wrMap     = regWrEn && addrOk && addrIsMap;
    strb.wrValid   = regWrEn && addrOk && addrIsValid;
    strb.rdMap     = regRdEn && addrOk && addrIsMap;
    strb.rdValid   = regRdEn && addrOk && addrIsValid;
    strb.regSel    = regAddr[2:0];
    strb.mapActive = tablePresent && hypEnabled && levelEn;
  end

  // R7/R8: an undefined access never reaches the storage
  p_undef_no_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    regUndef |-> !strb.wrMap && !strb.wrValid);

  // R6: hypervisor level disabled forces pass-through
  p_hyp_off_pass_r6: assert property (@(posedge clk) disable iff (!rstN)
    !hypEnabled |-> !strb.mapActive);
endmodule

// File: rtl/vpm_datapath.sv
module vpm_datapath
  import vpm_pkg::*;
#(
  parameter int MAX_REG_IDX = 7,
  parameter int VID_W       = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  vpmStrb_t         strb,
  input  logic [MAP_W-1:0] regWrData,
  output logic [MAP_W-1:0] regRdData,
  input  logic [VID_W-1:0] vidIn,
  output logic [ENT_W-1:0] pidOut,
  output logic             xlFault
);
  localparam int NUM_REGS = MAX_REG_IDX + 1;
  localparam int NUM_ENT  = NUM_REGS * ENT_PER_REG;

  logic [MAP_W-1:0]   mapRegs [NUM_REGS];
  logic [NUM_ENT-1:0] validVec;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_map
    always_ff @(posedge clk) begin
      if (!rstN)
        mapRegs[g] <= '0;
      else if (strb.wrMap && strb.regSel == 3'(g))
        mapRegs[g] <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      validVec <= '0;
    else if (strb.wrValid)
      validVec <= regWrData[NUM_ENT-1:0];
  end

  always_comb begin
    regRdData = '0;
    if (strb.rdValid)
      regRdData = MAP_W'(validVec);
    for (int i = 0; i < NUM_REGS; i++)
      if (strb.rdMap && strb.regSel == 3'(i))
        regRdData = mapRegs[i];
  end

  logic             inRange, hitValid;
  logic [ENT_W-1:0] hitEnt;

  always_comb begin
    inRange  = 32'(vidIn) < NUM_ENT;
    hitValid = 1'b0;
    hitEnt   = '0;
    for (int i = 0; i < NUM_REGS; i++)
      for (int j = 0; j < ENT_PER_REG; j++)
        if (32'(vidIn) == i * ENT_PER_REG + j) begin
          hitEnt   = mapRegs[i][j*ENT_W +: ENT_W];
          hitValid = validVec[i*ENT_PER_REG + j];
        end

    pidOut  = '0;
    xlFault = 1'b0;
    if (!strb.mapActive)
      pidOut[VID_W-1:0] = vidIn;
    else if (!inRange || !hitValid)
      xlFault = 1'b1;
    else
      pidOut = hitEnt;
  end

  // R3: a fault never carries a physical ID
  p_fault_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    xlFault |-> pidOut == '0);

  // R4: out-of-range IDs fault whenever mapping applies
  p_out_of_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mapActive && 32'(vidIn) >= NUM_ENT) |-> xlFault);

  // R5: an unmapped request never faults
  p_unmapped_no_fault_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.mapActive |-> !xlFault);

  // R8: valid bitmap holds when no decoded write occurs
  p_valid_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrValid |=> $stable(validVec));

  // R2/R10: valid bitmap takes the written value after the edge
  p_valid_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrValid |=> validVec == $past(regWrData[NUM_ENT-1:0]));
endmodule

// File: rtl/vpart_map.sv
module vpart_map
  import vpm_pkg::*;
#(
  parameter int MAX_REG_IDX = 7,
  parameter int VID_W       = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             featPresent,
  input  logic             hypCtlPresent,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [3:0]       regAddr,
  input  logic [63:0]      regWrData,
  output logic [63:0]      regRdData,
  output logic             regUndef,
  input  logic             hypEnabled,
  input  logic             kernMapEn,
  input  logic             userMapEn,
  input  logic             reqUser,
  input  logic [VID_W-1:0] vidIn,
  output logic [15:0]      pidOut,
  output logic             xlFault
);
  vpmStrb_t strb;

  vpm_ctrl #(.MAX_REG_IDX(MAX_REG_IDX)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .featPresent  (featPresent),
    .hypCtlPresent(hypCtlPresent),
    .regWrEn      (regWrEn),
    .regRdEn      (regRdEn),
    .regAddr      (regAddr),
    .hypEnabled   (hypEnabled),
    .kernMapEn    (kernMapEn),
    .userMapEn    (userMapEn),
    .reqUser      (reqUser),
    .strb         (strb),
    .regUndef     (regUndef)
  );

  vpm_datapath #(.MAX_REG_IDX(MAX_REG_IDX), .VID_W(VID_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .vidIn    (vidIn),
    .pidOut   (pidOut),
    .xlFault  (xlFault)
  );
endmodule

// File: tb/vpart_map_test.sv
module vpart_map_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXI       = 3;
  localparam int VW         = 6;

  logic          clk = 0;
  logic          rstN = 0;
  logic          featPresent = 1, hypCtlPresent = 1;
  logic          regWrEn = 0, regRdEn = 0;
  logic [3:0]    regAddr = 0;
  logic [63:0]   regWrData = 0;
  logic [63:0]   regRdData;
  logic          regUndef;
  logic          hypEnabled = 1, kernMapEn = 1, userMapEn = 1, reqUser = 0;
  logic [VW-1:0] vidIn = 0;
  logic [15:0]   pidOut;
  logic          xlFault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpart_map #(.MAX_REG_IDX(MAXI), .VID_W(VW)) uut (
    .clk(clk), .rstN(rstN), .featPresent(featPresent), .hypCtlPresent(hypCtlPresent),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .regUndef(regUndef), .hypEnabled(hypEnabled),
    .kernMapEn(kernMapEn), .userMapEn(userMapEn), .reqUser(reqUser),
    .vidIn(vidIn), .pidOut(pidOut), .xlFault(xlFault));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [63:0] d, output logic u);
    @(negedge clk);
    regAddr = a; regRdEn = 1;
    #1;
    d = regRdData; u = regUndef;
    regRdEn = 0;
  endtask

  task automatic xl(input string req, input int vid, input logic usr,
                    input logic [15:0] expPid, input logic expFault);
    @(negedge clk);
    vidIn = VW'(vid); reqUser = usr;
    #1;
    check({req, " pid"}, 64'(pidOut), 64'(expPid));
    check({req, " fault"}, 64'(xlFault), 64'(expFault));
  endtask

  task automatic t_reset;
    logic [63:0] d; logic u;
    for (int a = 0; a <= MAXI; a++) begin
      rdReg(4'(a), d, u);
      check("R9 map reg after reset", d, 64'h0);
    end
    rdReg(4'd8, d, u);
    check("R9 valid after reset", d, 64'h0);
    xl("R9 vid0 invalid after reset", 0, 0, 16'h0, 1);
  endtask

  task automatic t_pack;
    wrReg(4'd0, 64'h4444_3333_2222_1111);
    wrReg(4'd2, 64'hC00C_B00B_A00A_9009);
    wrReg(4'd8, 64'h0000_FFFF);
    xl("R1 vid0", 0, 0, 16'h1111, 0);
    xl("R1 vid1", 1, 0, 16'h2222, 0);
    xl("R1 vid3", 3, 0, 16'h4444, 0);
    xl("R1 vid8", 8, 0, 16'h9009, 0);
    xl("R1 vid10", 10, 0, 16'hB00B, 0);
    // R10: new value visible on the negedge right after the write edge
    @(negedge clk);
    regAddr = 4'd3; regWrData = 64'h0DEF_0000_0000_0000; regWrEn = 1; vidIn = VW'(15);
    @(negedge clk);
    regWrEn = 0;
    #1;
    check("R10 translate after write", 64'(pidOut), 64'h0DEF);
  endtask

  task automatic t_valid;
    wrReg(4'd8, 64'h0000_FFDF);
    xl("R3 vid5 invalid", 5, 0, 16'h0, 1);
    xl("R3 vid0 still valid", 0, 0, 16'h1111, 0);
  endtask

  task automatic t_range;
    logic [63:0] d; logic u;
    wrReg(4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    rdReg(4'd8, d, u);
    check("R2 valid readback width", d, 64'h0000_FFFF);
    check("R2 valid addr defined", 64'(u), 64'h0);
    xl("R4 vid16", 16, 0, 16'h0, 1);
    xl("R4 vid63", 63, 1, 16'h0, 1);
  endtask

  task automatic t_level;
    @(negedge clk); kernMapEn = 1; userMapEn = 0;
    xl("R5 user disabled passthrough", 9, 1, 16'd9, 0);
    xl("R5 kernel enabled mapped", 9, 0, 16'hA00A, 0);
    @(negedge clk); kernMapEn = 0; userMapEn = 1;
    xl("R5 kernel disabled passthrough", 40, 0, 16'd40, 0);
    xl("R5 user enabled mapped", 2, 1, 16'h3333, 0);
    @(negedge clk); kernMapEn = 1; userMapEn = 1;
  endtask

  task automatic t_hyp;
    @(negedge clk); hypEnabled = 0;
    xl("R6 hyp off vid2", 2, 0, 16'd2, 0);
    xl("R6 hyp off vid40", 40, 1, 16'd40, 0);
    @(negedge clk); hypEnabled = 1;
  endtask

  task automatic t_undef;
    logic [63:0] d; logic u;
    @(negedge clk); featPresent = 0;
    regAddr = 4'd0; regWrData = 64'hFFFF_FFFF_FFFF_FFFF; regWrEn = 1;
    #1;
    check("R7 write undef", 64'(regUndef), 64'h1);
    @(negedge clk); regWrEn = 0;
    rdReg(4'd0, d, u);
    check("R7 read undef", 64'(u), 64'h1);
    check("R7 read zero", d, 64'h0);
    xl("R7 absent passthrough", 1, 0, 16'd1, 0);
    @(negedge clk); featPresent = 1; hypCtlPresent = 0;
    rdReg(4'd8, d, u);
    check("R7 hypctl absent undef", 64'(u), 64'h1);
    @(negedge clk); hypCtlPresent = 1;
    rdReg(4'd0, d, u);
    check("R7 write dropped", d, 64'h4444_3333_2222_1111);
  endtask

  task automatic t_addr;
    logic [63:0] d; logic u;
    wrReg(4'd5, 64'h1234);
    wrReg(4'd12, 64'h5678);
    rdReg(4'd5, d, u);
    check("R8 addr5 undef", 64'(u), 64'h1);
    check("R8 addr5 zero", d, 64'h0);
    rdReg(4'd12, d, u);
    check("R8 addr12 undef", 64'(u), 64'h1);
    rdReg(4'd1, d, u);
    check("R8 reg1 untouched", d, 64'h0);
    check("R8 reg1 defined", 64'(u), 64'h0);
    rdReg(4'd2, d, u);
    check("R2 reg2 readback", d, 64'hC00C_B00B_A00A_9009);
    rdReg(4'd8, d, u);
    check("R8 valid untouched", d, 64'h0000_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset;
    t_pack;
    t_valid;
    t_range;
    t_level;
    t_hyp;
    t_undef;
    t_addr;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule